// File: doc/BRIEF.md
# Per-Core Boost Frequency Governor

This block chooses the target clock frequency of one core. A sensor report arrives on a single-cycle strobe about once per millisecond. It carries a temperature in whole degrees Celsius, a power figure in milliwatts and a flag that marks a supply droop. On each report the governor produces a new frequency code, counted in 25 MHz units. It raises the code by one unit when there is power and thermal margin. It lowers the code by one unit when a limit is exceeded. On a droop it drops the code at once by a configurable number of units.

The code is kept between a base code and a boost ceiling. When the reported temperature shows ample headroom, the ceiling rises by an extension of 100 MHz or 50 MHz, chosen by a grade input. Adaptive control applies only in the top performance state. Outside that state the code requested by the operating system is passed through. In overclock mode, while in the top state, a fixed user code is passed through. The new code appears together with a one-cycle valid strobe, one clock after the report. Between reports the code does not change.

Top module: `freq_step_governor`

## Requirements
- R1: A clock edge with `rst` high sets `freq_code` to `base_code` and drives `freq_vld` low.
- R2: The governor updates `freq_code` and raises `freq_vld` on the edge that follows a cycle with `sample_vld` high. `freq_vld` is high for exactly that one cycle. Without a report, `freq_code` holds its value and `freq_vld` stays low.
- R3: In adaptive mode (`perf_top`=1, `oc_mode`=0), when there is no droop, `power_mw` < `power_budget` and `temp_c` + `temp_hyst` < `temp_limit`, the code rises by exactly one unit. One unit is 25 MHz.
- R4: In adaptive mode without droop, `power_mw` > `power_budget` or `temp_c` > `temp_limit` lowers the code by exactly one unit. The step-down check takes priority over the step-up check.
- R5: In adaptive mode without droop, when neither R3 nor R4 applies (inside the hysteresis band, or at exactly the budget or the limit), the code holds.
- R6: In adaptive mode, `droop`=1 lowers the code by `droop_steps` units in one report, whatever the other sensor values are. The result saturates at zero before clamping.
- R7: Every adaptive result is clamped. It is first limited to at most the ceiling and then raised to at least `base_code`, so the base wins when the two conflict. This clamp may move the code by more than one unit.
- R8: The ceiling is `boost_code` plus an extension. The extension applies only while `temp_c` < `ext_temp`. It is 4 units (100 MHz) when `ext_grade`=1 and 2 units (50 MHz) when `ext_grade`=0. The sum saturates at the largest code.
- R9: With `perf_top`=0 the next code is `os_code`, unclamped. All sensor inputs and `oc_mode` have no effect.
- R10: With `perf_top`=1 and `oc_mode`=1 the next code is `oc_code`, unclamped. Temperature, power and droop have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_vld | input | 1 | One-cycle strobe marking a sensor report |
| temp_c | input | TW | Reported temperature, 1 degree C per LSB |
| power_mw | input | PW | Reported power, 1 mW per LSB |
| droop | input | 1 | Supply droop flag of the report |
| perf_top | input | 1 | 1 while in the top performance state |
| oc_mode | input | 1 | Overclock mode, fixed frequency |
| os_code | input | FW | Code requested by the OS outside the top state |
| oc_code | input | FW | Fixed code used in overclock mode |
| base_code | input | FW | Lowest adaptive code |
| boost_code | input | FW | Boost ceiling without extension |
| ext_grade | input | 1 | Extension size: 1 = 4 units, 0 = 2 units |
| ext_temp | input | TW | Extension allowed when temperature is below this |
| temp_limit | input | TW | Temperature limit |
| temp_hyst | input | TW | Hysteresis margin for stepping up |
| power_budget | input | PW | Power budget in mW |
| droop_steps | input | SW | Units dropped on droop |
| freq_code | output | FW | Target frequency, 25 MHz per LSB |
| freq_vld | output | 1 | One-cycle strobe for a new code |

## Verification
Each result is due exactly one clock after the report that causes it, because a single register stage lies between `sample_vld` and both outputs. The bench drives each report on a falling edge and removes it on the next falling edge. It samples `freq_code` and `freq_vld` on that same falling edge, half a period after the updating edge. It also samples one cycle later to confirm that the strobe has dropped and the code holds. For the reset check, the bench samples on the falling edge after a rising edge with `rst` high.

// File: rtl/fgov_pkg.sv
package fgov_pkg;
  typedef enum logic [1:0] {
    MOVE_HOLD  = 2'd0,
    MOVE_UP    = 2'd1,
    MOVE_DOWN  = 2'd2,
    MOVE_DROOP = 2'd3
  } move_t;

  typedef enum logic [1:0] {
    SRC_ADAPT = 2'd0,
    SRC_OS    = 2'd1,
    SRC_OC    = 2'd2
  } src_t;
endpackage

// File: rtl/fgov_ceiling.sv
module fgov_ceiling #(
  parameter int FW     = 8,
  parameter int EXT_HI = 4,
  parameter int EXT_LO = 2
) (
  input  logic [FW-1:0] boost_code,
  input  logic          ext_grade,
  input  logic          ext_ok,
  output logic [FW-1:0] ceil_code
);
  localparam logic [FW:0]   HI_W   = (FW+1)'(EXT_HI);
  localparam logic [FW:0]   LO_W   = (FW+1)'(EXT_LO);
  localparam logic [FW-1:0] MAXC   = {FW{1'b1}};

  logic [FW:0] ext_w;
  logic [FW:0] sum_w;

  always_comb begin
    if (!ext_ok)        ext_w = '0;
    else if (ext_grade) ext_w = HI_W;
    else                ext_w = LO_W;
    sum_w = {1'b0, boost_code} + ext_w;
    ceil_code = sum_w[FW] ? MAXC : sum_w[FW-1:0];
  end
endmodule

// File: rtl/fgov_move_eval.sv
module fgov_move_eval
  import fgov_pkg::*;
#(
  parameter int TW = 8,
  parameter int PW = 18
) (
  input  logic [TW-1:0] temp_c,
  input  logic [PW-1:0] power_mw,
  input  logic          droop,
  input  logic [TW-1:0] temp_limit,
  input  logic [TW-1:0] temp_hyst,
  input  logic [PW-1:0] power_budget,
  output move_t         move
);
  logic [TW:0] temp_pad;
  logic        over_lim;
  logic        has_room;

  always_comb begin
    temp_pad = {1'b0, temp_c} + {1'b0, temp_hyst};
    over_lim = (power_mw > power_budget) || (temp_c > temp_limit);
    has_room = (power_mw < power_budget) && (temp_pad < {1'b0, temp_limit});
    if (droop)         move = MOVE_DROOP;
    else if (over_lim) move = MOVE_DOWN;
    else if (has_room) move = MOVE_UP;
    else               move = MOVE_HOLD;
  end
endmodule

// File: rtl/fgov_next.sv
module fgov_next
  import fgov_pkg::*;
#(
  parameter int FW = 8,
  parameter int SW = 4
) (
  input  logic [FW-1:0] cur_code,
  input  move_t         move,
  input  src_t          src,
  input  logic [SW-1:0] droop_steps,
  input  logic [FW-1:0] base_code,
  input  logic [FW-1:0] ceil_code,
  input  logic [FW-1:0] os_code,
  input  logic [FW-1:0] oc_code,
  output logic [FW-1:0] next_code
);
  localparam logic [FW:0] ONE_W = (FW+1)'(1);

  logic [FW:0]   cur_w;
  logic [FW:0]   drop_w;
  logic [FW:0]   cand_w;
  logic [FW-1:0] low_cap;
  logic [FW-1:0] clamped;

  always_comb begin
    cur_w  = {1'b0, cur_code};
    drop_w = (FW+1)'(droop_steps);
    case (move)
      MOVE_UP:    cand_w = cur_w + ONE_W;
      MOVE_DOWN:  cand_w = (cur_w == '0) ? '0 : cur_w - ONE_W;
      MOVE_DROOP: cand_w = (cur_w < drop_w) ? '0 : cur_w - drop_w;
      default:    cand_w = cur_w;
    endcase
    low_cap = (cand_w > {1'b0, ceil_code}) ? ceil_code : cand_w[FW-1:0];
    clamped = (low_cap < base_code) ? base_code : low_cap;
    case (src)
      SRC_OS:  next_code = os_code;
      SRC_OC:  next_code = oc_code;
      default: next_code = clamped;
    endcase
  end
endmodule

// File: rtl/freq_step_governor.sv
module freq_step_governor
  import fgov_pkg::*;
#(
  parameter int FW     = 8,
  parameter int TW     = 8,
  parameter int PW     = 18,
  parameter int SW     = 4,
  parameter int EXT_HI = 4,
  parameter int EXT_LO = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sample_vld,
  input  logic [TW-1:0] temp_c,
  input  logic [PW-1:0] power_mw,
  input  logic          droop,
  input  logic          perf_top,
  input  logic          oc_mode,
  input  logic [FW-1:0] os_code,
  input  logic [FW-1:0] oc_code,
  input  logic [FW-1:0] base_code,
  input  logic [FW-1:0] boost_code,
  input  logic          ext_grade,
  input  logic [TW-1:0] ext_temp,
  input  logic [TW-1:0] temp_limit,
  input  logic [TW-1:0] temp_hyst,
  input  logic [PW-1:0] power_budget,
  input  logic [SW-1:0] droop_steps,
  output logic [FW-1:0] freq_code,
  output logic          freq_vld
);
  logic [FW-1:0] ceil_code;
  logic [FW-1:0] next_code;
  logic [FW-1:0] code_q;
  logic          vld_q;
  move_t         move;
  src_t          src;

  always_comb begin
    if (!perf_top)    src = SRC_OS;
    else if (oc_mode) src = SRC_OC;
    else              src = SRC_ADAPT;
  end

  fgov_ceiling #(.FW(FW), .EXT_HI(EXT_HI), .EXT_LO(EXT_LO)) u_ceil (
    .boost_code (boost_code),
    .ext_grade  (ext_grade),
    .ext_ok     (temp_c < ext_temp),
    .ceil_code  (ceil_code)
  );

  fgov_move_eval #(.TW(TW), .PW(PW)) u_move (
    .temp_c       (temp_c),
    .power_mw     (power_mw),
    .droop        (droop),
    .temp_limit   (temp_limit),
    .temp_hyst    (temp_hyst),
    .power_budget (power_budget),
    .move         (move)
  );

  fgov_next #(.FW(FW), .SW(SW)) u_next (
    .cur_code    (code_q),
    .move        (move),
    .src         (src),
    .droop_steps (droop_steps),
    .base_code   (base_code),
    .ceil_code   (ceil_code),
    .os_code     (os_code),
    .oc_code     (oc_code),
    .next_code   (next_code)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= base_code;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= sample_vld;
      if (sample_vld) code_q <= next_code;
    end
  end

  assign freq_code = code_q;
  assign freq_vld  = vld_q;
endmodule

// File: rtl/fgov_checker.sv
module fgov_checker #(
  parameter int FW = 8,
  parameter int EXT_HI = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          sample_vld,
  input logic          droop,
  input logic          perf_top,
  input logic          oc_mode,
  input logic [FW-1:0] os_code,
  input logic [FW-1:0] oc_code,
  input logic [FW-1:0] base_code,
  input logic [FW-1:0] boost_code,
  input logic [FW-1:0] freq_code,
  input logic          freq_vld
);
  localparam logic [FW:0] ONE_W = (FW+1)'(1);
  localparam logic [FW:0] EXT_W = (FW+1)'(EXT_HI);

  logic adapt;
  assign adapt = perf_top && !oc_mode;

  AST_VLD_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (rst)
    sample_vld |=> freq_vld); // R2
  AST_NO_VLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !sample_vld |=> !freq_vld); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !sample_vld |=> $stable(freq_code)); // R2
  AST_ONE_UP: assert property (@(posedge clk) disable iff (rst)
    sample_vld && adapt && !droop && (freq_code >= base_code)
    |=> ({1'b0, freq_code} <= ({1'b0, $past(freq_code)} + ONE_W))); // R3
  AST_DROOP_NO_RISE: assert property (@(posedge clk) disable iff (rst)
    sample_vld && adapt && droop && (freq_code >= base_code)
    |=> (freq_code <= $past(freq_code))); // R6
  AST_FLOOR: assert property (@(posedge clk) disable iff (rst)
    sample_vld && adapt |=> (freq_code >= $past(base_code))); // R7
  AST_ROOF: assert property (@(posedge clk) disable iff (rst)
    sample_vld && adapt && (base_code <= boost_code)
    |=> ({1'b0, freq_code} <= ({1'b0, $past(boost_code)} + EXT_W))); // R8
  AST_OS_PASS: assert property (@(posedge clk) disable iff (rst)
    sample_vld && !perf_top |=> (freq_code == $past(os_code))); // R9
  AST_OC_PASS: assert property (@(posedge clk) disable iff (rst)
    sample_vld && perf_top && oc_mode |=> (freq_code == $past(oc_code))); // R10
endmodule

bind freq_step_governor fgov_checker #(.FW(FW), .EXT_HI(EXT_HI)) i_fgov_checker (
  .clk        (clk),
  .rst        (rst),
  .sample_vld (sample_vld),
  .droop      (droop),
  .perf_top   (perf_top),
  .oc_mode    (oc_mode),
  .os_code    (os_code),
  .oc_code    (oc_code),
  .base_code  (base_code),
  .boost_code (boost_code),
  .freq_code  (freq_code),
  .freq_vld   (freq_vld)
);

// File: tb/test_freq_step_governor.sv
module test_freq_step_governor;
  localparam int FW = 8;
  localparam int TW = 8;
  localparam int PW = 18;
  localparam int SW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          sample_vld = 1'b0;
  logic [TW-1:0] temp_c = '0;
  logic [PW-1:0] power_mw = '0;
  logic          droop = 1'b0;
  logic          perf_top = 1'b1;
  logic          oc_mode = 1'b0;
  logic [FW-1:0] os_code = 8'd100;
  logic [FW-1:0] oc_code = 8'd168;
  logic [FW-1:0] base_code = 8'd136;
  logic [FW-1:0] boost_code = 8'd152;
  logic          ext_grade = 1'b1;
  logic [TW-1:0] ext_temp = 8'd60;
  logic [TW-1:0] temp_limit = 8'd90;
  logic [TW-1:0] temp_hyst = 8'd5;
  logic [PW-1:0] power_budget = 18'd95000;
  logic [SW-1:0] droop_steps = 4'd3;
  logic [FW-1:0] freq_code;
  logic          freq_vld;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  freq_step_governor i_freq_step_governor (
    .clk(clk), .rst(rst), .sample_vld(sample_vld), .temp_c(temp_c),
    .power_mw(power_mw), .droop(droop), .perf_top(perf_top), .oc_mode(oc_mode),
    .os_code(os_code), .oc_code(oc_code), .base_code(base_code),
    .boost_code(boost_code), .ext_grade(ext_grade), .ext_temp(ext_temp),
    .temp_limit(temp_limit), .temp_hyst(temp_hyst), .power_budget(power_budget),
    .droop_steps(droop_steps), .freq_code(freq_code), .freq_vld(freq_vld)
  );

  typedef struct packed {
    logic [7:0]  t;
    logic [17:0] p;
    logic        d;
    logic [7:0]  exp;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{8'd50, 18'd50000, 1'b0, 8'd137},  // R3 up
    '{8'd50, 18'd50000, 1'b0, 8'd138},  // R3 up
    '{8'd86, 18'd50000, 1'b0, 8'd138},  // R5 hysteresis band
    '{8'd91, 18'd50000, 1'b0, 8'd137},  // R4 over temp
    '{8'd70, 18'd96000, 1'b0, 8'd136},  // R4 over power
    '{8'd70, 18'd96000, 1'b0, 8'd136},  // R7 floor
    '{8'd70, 18'd95000, 1'b0, 8'd136},  // R5 at budget
    '{8'd84, 18'd50000, 1'b0, 8'd137},  // R3 just inside margin
    '{8'd90, 18'd50000, 1'b0, 8'd137},  // R5 at limit
    '{8'd50, 18'd50000, 1'b1, 8'd136}   // R6 droop then R7 floor
  };

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sample(input int t, input int p, input bit d);
    @(negedge clk);
    temp_c = TW'(t);
    power_mw = PW'(p);
    droop = d;
    sample_vld = 1'b1;
    @(negedge clk);
    sample_vld = 1'b0;
  endtask

  task automatic report_done();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    report_done();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 reset code", freq_code, 136);
    check("R1 reset vld", freq_vld, 0);

    for (int i = 0; i < NV; i++) begin
      sample(VECS[i].t, VECS[i].p, VECS[i].d);
      check("R2 vld after sample", freq_vld, 1);
      check("R3/R4/R5/R6/R7 table", freq_code, VECS[i].exp);
    end

    @(negedge clk);
    check("R2 vld drops", freq_vld, 0);
    check("R2 code holds", freq_code, 136);

    for (int i = 0; i < 20; i++) sample(70, 50000, 0);
    check("R7 ceiling no ext", freq_code, 152);

    for (int i = 0; i < 8; i++) sample(50, 50000, 0);
    check("R8 ext grade1 4 steps", freq_code, 156);

    sample(70, 50000, 0);
    check("R8 ext lost clamps", freq_code, 152);

    ext_grade = 1'b0;
    for (int i = 0; i < 6; i++) sample(50, 50000, 0);
    check("R8 ext grade0 2 steps", freq_code, 154);

    sample(50, 50000, 1);
    check("R6 droop 3 steps", freq_code, 151);

    perf_top = 1'b0;
    sample(99, 200000, 1);
    check("R9 os code", freq_code, 100);
    oc_mode = 1'b1;
    sample(50, 50000, 0);
    check("R10 oc ignored outside top", freq_code, 100);

    perf_top = 1'b1;
    sample(99, 200000, 1);
    check("R10 oc code", freq_code, 168);

    oc_mode = 1'b0;
    sample(70, 50000, 0);
    check("R7 leave oc clamps", freq_code, 152);

    boost_code = 8'd254;
    ext_grade = 1'b1;
    perf_top = 1'b0;
    os_code = 8'd255;
    sample(50, 50000, 0);
    perf_top = 1'b1;
    sample(50, 50000, 0);
    check("R8 ceiling saturates", freq_code, 255);

    base_code = 8'd2;
    os_code = 8'd1;
    droop_steps = 4'd15;
    perf_top = 1'b0;
    sample(50, 50000, 0);
    perf_top = 1'b1;
    sample(50, 50000, 1);
    check("R6 droop saturates to base", freq_code, 2);

    @(negedge clk);
    rst = 1'b1;
    base_code = 8'd136;
    @(negedge clk);
    check("R1 reset again code", freq_code, 136);
    check("R1 reset again vld", freq_vld, 0);
    rst = 1'b0;

    report_done();
  end
endmodule